// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Engine

This block is the host side of a three-wire serial EEPROM link: select, serial clock and a data line in each direction. A client asks for a run of 16-bit words with a one-cycle start pulse, an operation bit, a first address and a word count. For a read, the engine sends one read command per word and returns each word on a read stream with a valid pulse. For a block write, it first unlocks the memory for programming. It then sends one write command per word, with the word taken from a write stream, and waits for the memory's ready indication after each word. Finally it locks the memory again.

All serial timing comes from the system clock. Each serial bit occupies one slot: the serial clock is low for `DIV` system cycles and then high for `DIV` system cycles. Select and outgoing data change only at slot boundaries, and incoming data is sampled at the last cycle of the low half. `ADDR_W` sets the address width, normally 6 or 8. A bounded ready poll turns a memory that never finishes into a sticky error flag instead of a hang.

Top module: `uwire_eeprom_host`

## Requirements
- R1: After reset, and whenever the engine is idle, select and serial clock are low, and busy, done and rd_valid are low.
- R2: Every serial clock high phase lasts exactly DIV system cycles. Select and outgoing data hold steady across the rising edge and throughout the high phase.
- R3: Every command opens with one slot that has select high and data 0. A start bit of 1 follows, then a two-bit opcode (read = 10, write = 01, control = 00), then ADDR_W address bits, most significant first.
- R4: A read clocks in 17 bits, sampled at the end of each clock low phase. The first bit is discarded and the other 16 form the word, most significant bit first. The word appears on rd_data with one rd_valid pulse.
- R5: A request for N words handles addresses start, start+1, …, start+N-1 modulo 2^ADDR_W, with one command per word.
- R6: A block write begins with an unlock command and ends with a lock command. Each is 3+ADDR_W bits long after the select slot. The unlock command is start, opcode 00, then an address field of 11 followed by zeros. The lock command is start, opcode 00, then an all-zero address field.
- R7: Each write command carries its 16 data bits, most significant first, right after the address. The word is taken from wr_data at the clock edge before the one-cycle wr_take pulse, once per word.
- R8: After the data bits, select drops for one slot and then rises again. Poll slots follow until the returned data is sampled as 1. The poll slot in which the 1 is seen completes before the next step.
- R9: Between commands, select stays low for one full clock slot (low then high).
- R10: If POLL_MAX poll slots pass without a ready indication, timeout_err is set, the remaining words are skipped and the lock command is still sent. timeout_err stays set until the next accepted start.
- R11: busy rises in the cycle after an accepted start and stays high until done. A start pulse while busy has no effect.
- R12: done is a single-cycle pulse in the first idle cycle. A word count of 0 gives done with no serial activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted only when idle |
| op_write | input | 1 | 1 = block write, 0 = block read |
| start_addr | input | ADDR_W | First word address |
| word_count | input | ADDR_W+1 | Number of words, 0 to 2^ADDR_W |
| wr_data | input | 16 | Write stream word, held until wr_take |
| wr_take | output | 1 | Pulse: wr_data was captured, present next word |
| rd_data | output | 16 | Read stream word |
| rd_valid | output | 1 | Pulse: rd_data holds a new word |
| busy | output | 1 | Request in progress |
| done | output | 1 | Pulse: request finished |
| timeout_err | output | 1 | Ready poll gave up during the last request |
| ee_cs | output | 1 | Memory select |
| ee_sk | output | 1 | Serial clock |
| ee_di | output | 1 | Serial data toward the memory |
| ee_do | input | 1 | Serial data from the memory |

## Verification
Reads are tried from a single mid-range address and as a four-word run that crosses the top of the address space. The wrap run shows whether the address increment is modular. A multi-word block write followed by a read-back of the same addresses separates the unlock/lock framing, data ordering and ready waiting from plain read behaviour. A memory model that never becomes ready exercises the timeout path and its word skipping. A start pulse while busy and requests of zero words show that ignored and empty requests leave the serial lines and the streams untouched.

// File: rtl/uwire_eeprom_host.sv
module uwire_eeprom_host #(
  parameter int ADDR_W   = 6,
  parameter int DIV      = 2,
  parameter int POLL_MAX = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_write,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W:0]   word_count,
  input  logic [15:0]       wr_data,
  output logic              wr_take,
  output logic [15:0]       rd_data,
  output logic              rd_valid,
  output logic              busy,
  output logic              done,
  output logic              timeout_err,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);
  localparam int CMD_W = 3 + ADDR_W;
  localparam int TXW   = CMD_W + 16;
  localparam int CW    = $clog2(TXW + 1);
  localparam int DW    = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int PW    = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;
  localparam logic [DW-1:0] DIV_LAST  = DW'(DIV - 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(POLL_MAX - 1);
  localparam logic [CW-1:0] CMD_LEN   = CW'(CMD_W);
  localparam logic [CW-1:0] WR_LEN    = CW'(TXW);
  localparam logic [CW-1:0] RX_LEN    = CW'(17);
  localparam logic [TXW-1:0] FR_UNLOCK = {5'b10011, {(TXW-5){1'b0}}};
  localparam logic [TXW-1:0] FR_LOCK   = {1'b1, {(TXW-1){1'b0}}};

  typedef enum logic [2:0] {P_IDLE, P_SEL, P_TX, P_RX, P_GAP, P_POLL, P_RST} phase_t;
  typedef enum logic [1:0] {S_UNLOCK, S_WORD, S_LOCK} stage_t;

  phase_t            phase;
  stage_t            stage;
  logic              is_wr, abort, half, ready_seen;
  logic [ADDR_W-1:0] addr;
  logic [ADDR_W:0]   left;
  logic [TXW-1:0]    tx_sr;
  logic [CW-1:0]     bit_cnt;
  logic [15:0]       rx_sr;
  logic [DW-1:0]     div_cnt;
  logic [PW-1:0]     poll_cnt;

  wire [ADDR_W-1:0] nxt_addr = addr + 1'b1;
  wire tick_lo  = busy && !half && div_cnt == DIV_LAST;
  wire slot_end = busy &&  half && div_cnt == DIV_LAST;

  assign busy    = phase != P_IDLE;
  assign ee_sk   = half;
  assign ee_cs   = phase == P_SEL || phase == P_TX || phase == P_RX || phase == P_POLL;
  assign ee_di   = phase == P_TX && tx_sr[TXW-1];
  assign rd_data = rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= P_IDLE; stage <= S_WORD;
      is_wr <= 1'b0; abort <= 1'b0; half <= 1'b0; ready_seen <= 1'b0;
      addr <= '0; left <= '0; tx_sr <= '0; bit_cnt <= '0; rx_sr <= '0;
      div_cnt <= '0; poll_cnt <= '0;
      wr_take <= 1'b0; rd_valid <= 1'b0; done <= 1'b0; timeout_err <= 1'b0;
    end else begin
      wr_take  <= 1'b0;
      rd_valid <= 1'b0;
      done     <= 1'b0;

      if (!busy) begin
        div_cnt <= '0;
        half    <= 1'b0;
      end else if (div_cnt == DIV_LAST) begin
        div_cnt <= '0;
        half    <= ~half;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end

      case (phase)
        P_IDLE: if (start) begin
          timeout_err <= 1'b0;
          abort       <= 1'b0;
          is_wr       <= op_write;
          addr        <= start_addr;
          left        <= word_count;
          bit_cnt     <= CMD_LEN;
          if (word_count == '0) begin
            done <= 1'b1;
          end else if (op_write) begin
            stage <= S_UNLOCK;
            tx_sr <= FR_UNLOCK;
            phase <= P_SEL;
          end else begin
            stage <= S_WORD;
            tx_sr <= {3'b110, start_addr, 16'h0000};
            phase <= P_SEL;
          end
        end

        P_SEL: if (slot_end) phase <= P_TX;

        P_TX: if (slot_end) begin
          tx_sr   <= tx_sr << 1;
          bit_cnt <= bit_cnt - 1'b1;
          if (bit_cnt == CW'(1)) begin
            if (stage != S_WORD) phase <= P_RST;
            else if (is_wr)      phase <= P_GAP;
            else begin
              phase   <= P_RX;
              bit_cnt <= RX_LEN;
            end
          end
        end

        P_RX: begin
          if (tick_lo) rx_sr <= {rx_sr[14:0], ee_do};
          if (slot_end) begin
            bit_cnt <= bit_cnt - 1'b1;
            if (bit_cnt == CW'(1)) begin
              rd_valid <= 1'b1;
              phase    <= P_RST;
            end
          end
        end

        P_GAP: if (slot_end) begin
          phase      <= P_POLL;
          poll_cnt   <= '0;
          ready_seen <= 1'b0;
        end

        P_POLL: begin
          if (tick_lo && ee_do) ready_seen <= 1'b1;
          if (slot_end) begin
            if (ready_seen) begin
              phase <= P_RST;
            end else if (poll_cnt == POLL_LAST) begin
              timeout_err <= 1'b1;
              abort       <= 1'b1;
              phase       <= P_RST;
            end else begin
              poll_cnt <= poll_cnt + 1'b1;
            end
          end
        end

        P_RST: if (slot_end) begin
          phase <= P_SEL;
          case (stage)
            S_UNLOCK: begin
              stage   <= S_WORD;
              tx_sr   <= {3'b101, addr, wr_data};
              bit_cnt <= WR_LEN;
              wr_take <= 1'b1;
            end
            S_WORD: begin
              if (left > (ADDR_W+1)'(1) && !abort) begin
                addr <= nxt_addr;
                left <= left - 1'b1;
                if (is_wr) begin
                  tx_sr   <= {3'b101, nxt_addr, wr_data};
                  bit_cnt <= WR_LEN;
                  wr_take <= 1'b1;
                end else begin
                  tx_sr   <= {3'b110, nxt_addr, 16'h0000};
                  bit_cnt <= CMD_LEN;
                end
              end else if (is_wr) begin
                stage   <= S_LOCK;
                tx_sr   <= FR_LOCK;
                bit_cnt <= CMD_LEN;
              end else begin
                phase <= P_IDLE;
                done  <= 1'b1;
              end
            end
            default: begin
              phase <= P_IDLE;
              done  <= 1'b1;
            end
          endcase
        end

        default: phase <= P_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uwire_eeprom_host_chk.sv
module uwire_eeprom_host_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic rd_valid,
  input logic timeout_err,
  input logic ee_cs,
  input logic ee_sk,
  input logic ee_di
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ee_cs && !ee_sk));

  assert_rise_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_sk) |-> ($stable(ee_cs) && $stable(ee_di)));

  assert_read_in_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy);

  assert_err_in_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> busy);

  assert_busy_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind uwire_eeprom_host uwire_eeprom_host_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .rd_valid(rd_valid),
  .timeout_err(timeout_err), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di)
);

// File: tb/uwire_eeprom_host_tb_top.sv
module uwire_eeprom_host_tb_top;
  localparam int AW = 6;
  localparam int DV = 2;
  localparam int PM = 16;
  localparam int BS = 3;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, op_write = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [AW:0]   word_count = '0;
  logic [15:0]   wr_data;
  logic wr_take, rd_valid, busy, done, timeout_err, ee_cs, ee_sk, ee_di, ee_do;
  logic [15:0] rd_data;

  always #2 clk = ~clk;

  uwire_eeprom_host #(.ADDR_W(AW), .DIV(DV), .POLL_MAX(PM)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op_write(op_write),
    .start_addr(start_addr), .word_count(word_count), .wr_data(wr_data),
    .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy),
    .done(done), .timeout_err(timeout_err), .ee_cs(ee_cs), .ee_sk(ee_sk),
    .ee_di(ee_di), .ee_do(ee_do));

  int n_chk = 0, n_fail = 0;

  // ---------------- memory model ----------------
  logic [15:0] mem [DEPTH];
  logic [15:0] exp_mem [DEPTH];
  logic [1:0]  lg_op   [256];
  logic [AW-1:0] lg_addr [256];
  logic [15:0] lg_data [256];
  int          lg_lead [256];
  int lg_n = 0, lead = 0, nb = 0, busy_left = 0, idle_edges = 0, poll_edges = 0, viol = 0;
  logic started = 0, reading = 0, cmd_done = 0, pend = 0, polling = 0, ew = 0, stuck = 0, rbit = 0;
  logic [AW+17:0] cbuf = '0;
  logic [15:0] rsh = '0;

  assign ee_do = reading ? rbit : !(stuck || busy_left != 0);

  always @(posedge ee_sk or negedge ee_cs) begin
    if (!ee_cs) begin
      if (ee_sk) idle_edges++;
      started = 0; reading = 0; cmd_done = 0; lead = 0;
      if (pend) begin busy_left = BS; pend = 0; polling = 1; end
      else if (!ee_sk) polling = 0;
    end else if (!started) begin
      if (busy_left > 0) busy_left--;
      if (polling) poll_edges++;
      if (ee_di) begin
        started = 1; nb = 0; cbuf = '0;
        if (busy_left != 0 || stuck) viol++;
      end else lead++;
    end else if (reading) begin
      rbit = rsh[15]; rsh = rsh << 1;
    end else if (!cmd_done) begin
      cbuf = {cbuf[AW+16:0], ee_di}; nb++;
      if (nb == 2 + AW && cbuf[AW+1:AW] != 2'b01) begin
        lg_op[lg_n] = cbuf[AW+1:AW]; lg_addr[lg_n] = cbuf[AW-1:0];
        lg_data[lg_n] = '0; lg_lead[lg_n] = lead; lg_n++;
        if (cbuf[AW+1:AW] == 2'b10) begin
          rsh = mem[cbuf[AW-1:0]]; rbit = 0; reading = 1;
        end else begin
          if (cbuf[AW-1:AW-2] == 2'b11) ew = 1;
          if (cbuf[AW-1:AW-2] == 2'b00) ew = 0;
          cmd_done = 1;
        end
      end else if (nb == AW + 18) begin
        lg_op[lg_n] = cbuf[AW+17:AW+16]; lg_addr[lg_n] = cbuf[AW+15:16];
        lg_data[lg_n] = cbuf[15:0]; lg_lead[lg_n] = lead; lg_n++;
        if (ew) mem[cbuf[AW+15:16]] = cbuf[15:0];
        pend = 1; cmd_done = 1;
      end
    end
  end

  // ---------------- streams and line monitors ----------------
  logic [15:0] src [256];
  logic [15:0] rd_got [256];
  int wr_idx = 0, rd_n = 0, done_cnt = 0, cs_rise = 0, hi_run = 0, sk_viol = 0, line_viol = 0;
  logic p_sk = 0, p_cs = 0, p_di = 0;
  assign wr_data = src[wr_idx[7:0]];

  always @(negedge clk) begin
    if (wr_take) wr_idx++;
    if (rd_valid) begin rd_got[rd_n[7:0]] = rd_data; rd_n++; end
    if (done) done_cnt++;
    if (ee_cs && !p_cs) cs_rise++;
    if (ee_sk) hi_run++;
    else begin
      if (p_sk && hi_run != DV) sk_viol++;
      hi_run = 0;
    end
    if (ee_sk && (ee_cs != p_cs || ee_di != p_di)) line_viol++;
    p_sk = ee_sk; p_cs = ee_cs; p_di = ee_di;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input bit wr, input int a, input int n);
    int g = 0;
    @(negedge clk);
    op_write = wr; start_addr = AW'(a); word_count = (AW+1)'(n); start = 1;
    @(negedge clk);
    start = 0;
    while (!done && g < 100000) begin @(negedge clk); g++; end
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(!ee_cs && !ee_sk, "R1 lines idle after reset", {ee_cs, ee_sk}, 0);
    chk(!busy && !done && !rd_valid, "R1 status idle after reset", {busy, done, rd_valid}, 0);
  endtask

  task automatic t_read(input int a, input int n);
    int lb = lg_n, rb = rd_n, ib = idle_edges, db = done_cnt;
    run(0, a, n);
    chk(rd_n - rb == n, "R4 word count on read stream", rd_n - rb, n);
    chk(lg_n - lb == n, "R5 one command per word", lg_n - lb, n);
    chk(done_cnt - db == 1, "R12 one done pulse", done_cnt - db, 1);
    chk(idle_edges - ib == n, "R9 idle clock slot per command", idle_edges - ib, n);
    for (int k = 0; k < n; k++) begin
      int ea = (a + k) % DEPTH;
      chk(lg_op[lb+k] == 2'b10, "R3 read opcode", lg_op[lb+k], 2);
      chk(lg_addr[lb+k] == AW'(ea), "R5 read address sequence", lg_addr[lb+k], ea);
      chk(lg_lead[lb+k] == 1, "R3 single select slot before start", lg_lead[lb+k], 1);
      chk(rd_got[rb+k] == exp_mem[ea], "R4 read word value", rd_got[rb+k], exp_mem[ea]);
    end
  endtask

  task automatic t_write(input int a, input int n, input int seed);
    int lb = lg_n, wb = wr_idx, pb = poll_edges, vb = viol;
    for (int k = 0; k < n; k++) src[(wb + k) % 256] = 16'((seed * 40503 + k * 7919) ^ (k << 12));
    run(1, a, n);
    chk(lg_n - lb == n + 2, "R6 unlock, words, lock", lg_n - lb, n + 2);
    chk(lg_op[lb] == 2'b00 && lg_addr[lb] == {2'b11, {(AW-2){1'b0}}}, "R6 unlock frame", lg_addr[lb], 48);
    chk(lg_op[lb+n+1] == 2'b00 && lg_addr[lb+n+1] == '0, "R6 lock frame", lg_addr[lb+n+1], 0);
    chk(!ew, "R6 memory locked after write", ew, 0);
    chk(wr_idx - wb == n, "R7 one wr_take per word", wr_idx - wb, n);
    chk(poll_edges - pb == n * (BS + 1), "R8 poll slots until ready", poll_edges - pb, n * (BS + 1));
    chk(viol == vb, "R8 no command while memory busy", viol - vb, 0);
    chk(!timeout_err, "R10 no timeout when ready", timeout_err, 0);
    for (int k = 0; k < n; k++) begin
      int ea = (a + k) % DEPTH;
      chk(lg_op[lb+1+k] == 2'b01 && lg_addr[lb+1+k] == AW'(ea), "R5 write address sequence", lg_addr[lb+1+k], ea);
      chk(lg_data[lb+1+k] == src[(wb + k) % 256], "R7 write data bits", lg_data[lb+1+k], src[(wb + k) % 256]);
      exp_mem[ea] = src[(wb + k) % 256];
    end
    t_read(a, n);
  endtask

  task automatic t_timeout;
    int lb = lg_n, pb = poll_edges;
    stuck = 1;
    src[wr_idx % 256] = 16'h1357; src[(wr_idx + 1) % 256] = 16'h2468; src[(wr_idx + 2) % 256] = 16'h9abc;
    run(1, 20, 3);
    chk(timeout_err, "R10 timeout flag set", timeout_err, 1);
    chk(lg_n - lb == 3, "R10 remaining words skipped", lg_n - lb, 3);
    chk(lg_op[lb+2] == 2'b00 && lg_addr[lb+2] == '0, "R10 lock still sent", lg_addr[lb+2], 0);
    chk(poll_edges - pb == PM, "R10 poll slot limit", poll_edges - pb, PM);
    stuck = 0;
    exp_mem[20] = 16'h1357;
    wr_idx = wr_idx + 2;
    t_read(20, 1);
    chk(!timeout_err, "R10 flag cleared by next start", timeout_err, 0);
  endtask

  task automatic t_busy_start;
    int lb = lg_n, rb = rd_n, db = done_cnt, g = 0;
    @(negedge clk);
    op_write = 0; start_addr = 6'd10; word_count = 7'd2; start = 1;
    @(negedge clk);
    start = 0;
    chk(busy, "R11 busy after accepted start", busy, 1);
    repeat (30) @(negedge clk);
    op_write = 1; start_addr = 6'd40; word_count = 7'd5; start = 1;
    @(negedge clk);
    start = 0;
    while (!done && g < 100000) begin @(negedge clk); g++; end
    repeat (40) @(negedge clk);
    chk(!busy, "R11 ignored start leaves engine idle", busy, 0);
    chk(lg_n - lb == 2 && lg_op[lb+1] == 2'b10, "R11 no extra command", lg_n - lb, 2);
    chk(rd_n - rb == 2, "R11 read stream unchanged", rd_n - rb, 2);
    chk(done_cnt - db == 1, "R11 single done", done_cnt - db, 1);
    chk(rd_got[rb+1] == exp_mem[11], "R4 word after ignored start", rd_got[rb+1], exp_mem[11]);
  endtask

  task automatic t_zero;
    int cb = cs_rise, db = done_cnt, rb = rd_n, wb = wr_idx;
    run(0, 3, 0);
    run(1, 3, 0);
    chk(done_cnt - db == 2, "R12 done for zero count", done_cnt - db, 2);
    chk(cs_rise == cb, "R12 no select for zero count", cs_rise - cb, 0);
    chk(rd_n == rb && wr_idx == wb, "R12 streams untouched", rd_n - rb, 0);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = 16'((i * 16'h0b1d) ^ 16'hc35a);
      exp_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset;
    t_read(5, 1);
    t_read(62, 4);
    t_write(30, 3, 11);
    t_write(63, 2, 5);
    t_timeout;
    t_busy_start;
    t_zero;
    chk(sk_viol == 0, "R2 clock high time", sk_viol, 0);
    chk(line_viol == 0, "R2 lines steady while clock high", line_viol, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule